// File: doc/BRIEF.md
# Memory and Port Chip-Select Decoder

This block sits between a processor bus with a 16-bit address and its memory and port devices. On each bus cycle it inspects the address together with the cycle type (memory or I/O) and the active-low read and write strobes. For memory cycles it drives one of four active-low chip selects and passes the low address bits to the chosen device. For I/O cycles it compares the low address byte against two port numbers. A match on the output port during a write loads a register from the data bus. A match on the input port during a read raises the enable of an input buffer.

The memory map is fixed at elaboration. Address bit 13 enables the chip-select decoder and bits 12:11 pick the chip. With exhaustive decoding, bits 15:14 must also equal a parameterised tag, so every location has exactly one address. With partial decoding, bits 15:14 are ignored, so each chip shows up four times in the 64 KiB space.

Top module: `mem_port_decode`

## Requirements
- R1: `mem_cs_no` is active low and at most one bit is low at any time. All bits are high when `sel_io_i`=1 (I/O cycle), and also when both `rd_ni` and `wr_ni` are high.
- R2: In a memory cycle with a strobe low and address bit 13 = 1, `mem_cs_no[k]` is low where k = address bits 12:11. With bit 13 = 0, no select is low.
- R3: With `EXHAUSTIVE`=1, a select goes low only when address bits 15:14 equal `UPPER_TAG` (default 2'b00). Any other value leaves all selects high.
- R4: With `EXHAUSTIVE`=0, address bits 15:14 are ignored, so an address and the same address with other values in bits 15:14 select the same chip.
- R5: `port_q_o` loads `data_i` at the rising clock edge when `sel_io_i`=1, `wr_ni`=0 and address bits 7:0 equal `OUT_PORT` (default 8'h40). Bits 15:8 play no part in this match. In every other cycle, including memory writes and I/O reads of the same number, the register holds its value.
- R6: While `rst_ni` is low, `port_q_o` is 8'h00.
- R7: `in_en_o` is high, in the same cycle, exactly when `sel_io_i`=1, `rd_ni`=0 and address bits 7:0 equal `IN_PORT` (default 8'h41).
- R8: `mem_addr_o` always equals address bits 10:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| sel_io_i | input | 1 | Cycle type: 1 = I/O, 0 = memory |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Write data from the bus |
| mem_cs_no | output | 4 | Chip selects, active low |
| mem_addr_o | output | 11 | Address inside the selected chip |
| port_q_o | output | 8 | Output port register |
| in_en_o | output | 1 | Input buffer enable |

## Verification
The chip selects, the chip address and the input-buffer enable are combinational. The bench therefore checks them in the same cycle, a short delay after the inputs change. The output port register takes effect one edge later. The bench keeps its own model of this register, updates the model at the same rising edge, and compares it in the cycle that follows each write. The bench runs an exhaustive instance and a partial instance side by side on the same stimulus, so aliased addresses show the split between R3 and R4 directly.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  typedef enum logic {CYC_MEM = 1'b0, CYC_IO = 1'b1} cyc_e;

  function automatic logic strobe_any(input logic rd_n, input logic wr_n);
    return !(rd_n && wr_n);
  endfunction
endpackage

// File: rtl/mpd_dec.sv
module mpd_dec #(
  parameter int SEL_W = 2,
  localparam int NOUT = 1 << SEL_W
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [NOUT-1:0]  y_no
);
  for (genvar k = 0; k < NOUT; k++) begin : g_out
    assign y_no[k] = !(en_i && (sel_i == SEL_W'(k)));
  end
endmodule

// File: rtl/mpd_mem_sel.sv
module mpd_mem_sel #(
  parameter int ADDR_W     = 16,
  parameter int CHIP_AW    = 11,
  parameter int SEL_W      = 2,
  parameter bit EXHAUSTIVE = 1'b1,
  localparam int EN_BIT    = CHIP_AW + SEL_W,
  localparam int UP_W      = ADDR_W - EN_BIT - 1,
  localparam int NCHIP     = 1 << SEL_W,
  parameter logic [UP_W-1:0] UPPER_TAG = '0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  mpd_pkg::cyc_e      cyc_i,
  input  logic               rd_ni,
  input  logic               wr_ni,
  output logic [NCHIP-1:0]   cs_no,
  output logic [CHIP_AW-1:0] chip_addr_o
);
  logic upper_ok;
  logic dec_en;

  if (EXHAUSTIVE) begin : g_full
    assign upper_ok = (addr_i[ADDR_W-1:EN_BIT+1] == UPPER_TAG);
  end else begin : g_fold
    assign upper_ok = 1'b1;
  end

  assign dec_en = (cyc_i == mpd_pkg::CYC_MEM) && mpd_pkg::strobe_any(rd_ni, wr_ni)
                  && addr_i[EN_BIT] && upper_ok;

  mpd_dec #(.SEL_W(SEL_W)) u_dec (
    .en_i (dec_en),
    .sel_i(addr_i[EN_BIT-1:CHIP_AW]),
    .y_no (cs_no)
  );

  assign chip_addr_o = addr_i[CHIP_AW-1:0];
endmodule

// File: rtl/mpd_io_port.sv
module mpd_io_port #(
  parameter int PORT_W = 8,
  parameter int DATA_W = 8,
  parameter logic [PORT_W-1:0] OUT_PORT = 8'h40,
  parameter logic [PORT_W-1:0] IN_PORT  = 8'h41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_i,
  input  mpd_pkg::cyc_e     cyc_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] q_o,
  output logic              in_en_o
);
  logic io_wr, io_rd;

  assign io_wr = (cyc_i == mpd_pkg::CYC_IO) && !wr_ni;
  assign io_rd = (cyc_i == mpd_pkg::CYC_IO) && !rd_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          q_o <= '0;
    else if (io_wr && port_i == OUT_PORT) q_o <= data_i;
  end

  assign in_en_o = io_rd && (port_i == IN_PORT);
endmodule

// File: rtl/mem_port_decode.sv
module mem_port_decode #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PORT_W     = 8,
  parameter int CHIP_AW    = 11,
  parameter int SEL_W      = 2,
  parameter bit EXHAUSTIVE = 1'b1,
  localparam int UP_W      = ADDR_W - CHIP_AW - SEL_W - 1,
  localparam int NCHIP     = 1 << SEL_W,
  parameter logic [UP_W-1:0]   UPPER_TAG = '0,
  parameter logic [PORT_W-1:0] OUT_PORT  = 8'h40,
  parameter logic [PORT_W-1:0] IN_PORT   = 8'h41
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               sel_io_i,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic [DATA_W-1:0]  data_i,
  output logic [NCHIP-1:0]   mem_cs_no,
  output logic [CHIP_AW-1:0] mem_addr_o,
  output logic [DATA_W-1:0]  port_q_o,
  output logic               in_en_o
);
  mpd_pkg::cyc_e cyc;
  assign cyc = sel_io_i ? mpd_pkg::CYC_IO : mpd_pkg::CYC_MEM;

  mpd_mem_sel #(
    .ADDR_W(ADDR_W), .CHIP_AW(CHIP_AW), .SEL_W(SEL_W),
    .EXHAUSTIVE(EXHAUSTIVE), .UPPER_TAG(UPPER_TAG)
  ) u_mem (
    .addr_i     (addr_i),
    .cyc_i      (cyc),
    .rd_ni      (rd_ni),
    .wr_ni      (wr_ni),
    .cs_no      (mem_cs_no),
    .chip_addr_o(mem_addr_o)
  );

  mpd_io_port #(
    .PORT_W(PORT_W), .DATA_W(DATA_W), .OUT_PORT(OUT_PORT), .IN_PORT(IN_PORT)
  ) u_io (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .port_i (addr_i[PORT_W-1:0]),
    .cyc_i  (cyc),
    .rd_ni  (rd_ni),
    .wr_ni  (wr_ni),
    .data_i (data_i),
    .q_o    (port_q_o),
    .in_en_o(in_en_o)
  );
endmodule

// File: rtl/mem_port_decode_chk.sv
module mem_port_decode_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PORT_W     = 8,
  parameter int CHIP_AW    = 11,
  parameter int SEL_W      = 2,
  parameter bit EXHAUSTIVE = 1'b1,
  localparam int UP_W      = ADDR_W - CHIP_AW - SEL_W - 1,
  localparam int NCHIP     = 1 << SEL_W,
  localparam int EN_BIT    = CHIP_AW + SEL_W,
  parameter logic [UP_W-1:0]   UPPER_TAG = '0,
  parameter logic [PORT_W-1:0] OUT_PORT  = 8'h40,
  parameter logic [PORT_W-1:0] IN_PORT   = 8'h41
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               sel_io_i,
  input logic               rd_ni,
  input logic               wr_ni,
  input logic [DATA_W-1:0]  data_i,
  input logic [NCHIP-1:0]   mem_cs_no,
  input logic [DATA_W-1:0]  port_q_o,
  input logic               in_en_o
);
  logic any_cs, out_load;
  assign any_cs   = (mem_cs_no != '1);
  assign out_load = sel_io_i && !wr_ni && (addr_i[PORT_W-1:0] == OUT_PORT);

  assert_cs_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));
  assert_cs_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_io_i || (rd_ni && wr_ni)) |-> !any_cs);
  assert_cs_enbit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cs |-> addr_i[EN_BIT]);
  assert_cs_index_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cs |-> !mem_cs_no[addr_i[EN_BIT-1:CHIP_AW]]);

  if (EXHAUSTIVE) begin : g_full
    assert_cs_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_cs |-> (addr_i[ADDR_W-1:EN_BIT+1] == UPPER_TAG));
  end

  assert_port_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_load |=> (port_q_o == $past(data_i)));
  assert_port_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_load |=> $stable(port_q_o));
  assert_in_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_en_o |-> (sel_io_i && !rd_ni && addr_i[PORT_W-1:0] == IN_PORT));
endmodule

bind mem_port_decode mem_port_decode_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W), .CHIP_AW(CHIP_AW),
  .SEL_W(SEL_W), .EXHAUSTIVE(EXHAUSTIVE), .UPPER_TAG(UPPER_TAG),
  .OUT_PORT(OUT_PORT), .IN_PORT(IN_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .sel_io_i(sel_io_i),
  .rd_ni(rd_ni), .wr_ni(wr_ni), .data_i(data_i), .mem_cs_no(mem_cs_no),
  .port_q_o(port_q_o), .in_en_o(in_en_o)
);

// File: tb/test_mem_port_decode.sv
`timescale 1ns/1ps
module test_mem_port_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        sel_io = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  data = '0;

  logic [3:0]  cs_f, cs_p;
  logic [10:0] ma_f, ma_p;
  logic [7:0]  q_f, q_p;
  logic        ie_f, ie_p;

  int checks = 0, failures = 0;
  bit timed_out = 0;
  logic [7:0] exp_q = 8'h00;

  always #2.5 clk = ~clk;

  mem_port_decode i_mem_port_decode (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .sel_io_i(sel_io), .rd_ni(rd_n),
    .wr_ni(wr_n), .data_i(data), .mem_cs_no(cs_f), .mem_addr_o(ma_f),
    .port_q_o(q_f), .in_en_o(ie_f));

  mem_port_decode #(.EXHAUSTIVE(1'b0)) i_mem_port_decode_part (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .sel_io_i(sel_io), .rd_ni(rd_n),
    .wr_ni(wr_n), .data_i(data), .mem_cs_no(cs_p), .mem_addr_o(ma_p),
    .port_q_o(q_p), .in_en_o(ie_p));

  // reference register: I/O write to port 40h
  always @(posedge clk or negedge rst_n)
    if (!rst_n) exp_q <= 8'h00;
    else if (sel_io && !wr_n && addr[7:0] == 8'h40) exp_q <= data;

  function automatic logic [3:0] ref_cs(input bit full);
    int idx;
    if (sel_io || (rd_n && wr_n) || !addr[13]) return 4'hF;
    if (full && addr[15:14] != 2'b00) return 4'hF;
    idx = int'(addr[12:11]);
    return ~(4'b0001 << idx);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " cs full"}, int'(cs_f), int'(ref_cs(1'b1)));
    chk({tag, " cs part"}, int'(cs_p), int'(ref_cs(1'b0)));
    chk("R8 chip addr", int'(ma_f), int'(addr[10:0]));
    chk("R8 chip addr part", int'(ma_p), int'(addr[10:0]));
    chk({tag, " port q"}, int'(q_f), int'(exp_q));
    chk({tag, " port q part"}, int'(q_p), int'(exp_q));
    chk({tag, " in_en"}, int'(ie_f), int'(sel_io && !rd_n && addr[7:0] == 8'h41));
    chk({tag, " in_en part"}, int'(ie_p), int'(sel_io && !rd_n && addr[7:0] == 8'h41));
  endtask

  task automatic step(input string tag, input logic [15:0] a, input logic io,
                      input logic rn, input logic wn, input logic [7:0] d);
    @(posedge clk);
    #1;
    addr = a; sel_io = io; rd_n = rn; wr_n = wn; data = d;
    #1;
    check_all(tag);
  endtask

  task automatic run();
    #1;
    chk("R6 port q in reset", int'(q_f), 0);
    chk("R1 cs idle in reset", int'(cs_f), 15);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R6", 16'h0000, 1'b0, 1'b1, 1'b1, 8'h00);
    // R2 chip index from bits 12:11, bit 13 enable
    step("R2 chip0", 16'h2000, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R2 chip0 value", int'(cs_f), 14);
    step("R2 chip1", 16'h2800, 1'b0, 1'b0, 1'b1, 8'h00);
    step("R2 chip2", 16'h3123, 1'b0, 1'b1, 1'b0, 8'h00);
    step("R2 chip3", 16'h3FFF, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R2 chip3 value", int'(cs_f), 7);
    step("R2 en low", 16'h1800, 1'b0, 1'b0, 1'b1, 8'h00);
    step("R1 no strobe", 16'h2000, 1'b0, 1'b1, 1'b1, 8'h00);
    step("R1 io cycle", 16'h2800, 1'b1, 1'b0, 1'b1, 8'h00);
    // R3/R4 alias in bits 15:14
    step("R3 R4 alias 01", 16'h6000, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R3 exhaustive rejects", int'(cs_f), 15);
    chk("R4 partial aliases", int'(cs_p), 14);
    step("R3 R4 alias 11", 16'hF7FF, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R4 partial chip2 alias", int'(cs_p), 11);
    // R5 output port
    step("R5 io write", 16'h0040, 1'b1, 1'b1, 1'b0, 8'hA5);
    step("R5 after write", 16'h0000, 1'b0, 1'b1, 1'b1, 8'h00);
    chk("R5 loaded", int'(q_f), 8'hA5);
    step("R5 mem write same byte", 16'h0040, 1'b0, 1'b1, 1'b0, 8'h3C);
    step("R5 io read out port", 16'h0040, 1'b1, 1'b0, 1'b1, 8'h77);
    step("R5 io write other port", 16'h0041, 1'b1, 1'b1, 1'b0, 8'h11);
    step("R5 hold", 16'h0000, 1'b0, 1'b1, 1'b1, 8'h00);
    chk("R5 held", int'(q_f), 8'hA5);
    step("R5 high byte ignored", 16'h1240, 1'b1, 1'b1, 1'b0, 8'h5A);
    step("R5 after high byte", 16'h0000, 1'b1, 1'b1, 1'b1, 8'h00);
    chk("R5 loaded 5A", int'(q_p), 8'h5A);
    // R7 input enable
    step("R7 io read in port", 16'h7741, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R7 enable high", int'(ie_f), 1);
    step("R7 io write in port", 16'h0041, 1'b1, 1'b1, 1'b0, 8'h00);
    step("R7 mem read in port", 16'h0041, 1'b0, 1'b0, 1'b1, 8'h00);
    step("R7 io read wrong port", 16'h0042, 1'b1, 1'b0, 1'b1, 8'h00);
    // R6 reset clears the register
    @(posedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk("R6 cleared", int'(q_f), 0);
    chk("R6 cleared part", int'(q_p), 0);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    fork
      run();
      begin
        #100000;
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule